// File: doc/BRIEF.md
# Software Write-Protection Sequence Detector

This block sits between a host write port and a page-programming engine. It sees every completed byte write as an address and a data byte. It finds the fixed command sequences that arm and disarm software write protection. For each write it gives a registered verdict: the byte may go into the page buffer, the byte was used as a command byte, or the byte is dropped. It also holds the protection flag that the page engine and the host can read.

The engine sends a one-cycle `page_end` pulse when its programming period finishes. A pending arm or disarm takes effect on that pulse, even when no data byte was loaded after the command. While protection is active, a page is accepted only after the three-byte unlock prefix has been given. After any completed command, a window of up to `PAGE_BYTES` data bytes stays open until `page_end`. The protection flag can optionally ignore reset, which models non-volatile retention.

Top module: `wp_guard`

## Requirements
- R1: After the first reset, `wr_allow` and `wr_cmd` are 0 and `prot_on` is 0.
- R2: While unprotected, a write that is not used as a command byte sets `wr_allow` for exactly one cycle, in the cycle after the write is presented.
- R3: The arm sequence is data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. Only address bits 14..0 are compared, so bits above bit 14 are ignored. Each byte of a matched sequence raises `wr_cmd` and never raises `wr_allow`.
- R4: `prot_on` goes to 1 in the cycle after the `page_end` pulse that follows a completed arm sequence, even when no data byte was written in between. It never changes in a cycle that does not follow `page_end`.
- R5: While protected, a write with no preceding unlock prefix in the current page is dropped: both `wr_allow` and `wr_cmd` stay 0.
- R6: While protected, once the three-byte prefix (the same bytes as in R3) has been given, the next data writes are allowed until `page_end`, up to `PAGE_BYTES` bytes. Any further byte in that page is dropped.
- R7: The disarm sequence is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. `prot_on` goes to 0 in the cycle after the next `page_end`.
- R8: A write that does not continue a partly matched sequence returns the matcher to idle. If that write is itself 0xAA@0x5555, it starts a new sequence as a command byte. Otherwise it is handled as data: it is allowed when unprotected and dropped when protected with no window open.
- R9: With `RETAIN_PROT`=1, asserting `rst` does not change `prot_on`.
- R10: While a data window is open, every write is data, including bytes that match command values. Such writes never raise `wr_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One completed byte write this cycle |
| wr_addr | input | ADDR_W (17) | Byte address of the write |
| wr_data | input | 8 | Byte value of the write |
| page_end | input | 1 | Pulse: the engine's programming period has ended |
| wr_allow | output | 1 | Registered: the last write may be loaded into the page |
| wr_cmd | output | 1 | Registered: the last write was used as a command byte |
| prot_on | output | 1 | Software protection flag |

## Verification
Both per-write verdicts, `wr_allow` and `wr_cmd`, are registered. They are due exactly one cycle after the write is presented. `prot_on` changes one cycle after the `page_end` pulse. The bench drives each write or pulse on a falling edge for a single cycle, then samples on the next falling edge. That falling edge lies after the one rising edge that registers the result. A check therefore never reads a value from the wrong stimulus. The state that a dropped or broken write could have affected is then observed through the next write's verdict and through `prot_on`.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_ESC3,
    SQ_ESC4,
    SQ_ESC5
  } seq_t;

  localparam logic [14:0] KEY_A_ADDR = 15'h5555;
  localparam logic [14:0] KEY_B_ADDR = 15'h2AAA;
  localparam logic [7:0]  KEY_A_DATA = 8'hAA;
  localparam logic [7:0]  KEY_B_DATA = 8'h55;
  localparam logic [7:0]  OP_ARM     = 8'hA0;
  localparam logic [7:0]  OP_ESCAPE  = 8'h80;
  localparam logic [7:0]  OP_DISARM  = 8'h20;
endpackage

// File: rtl/wp_seq_matcher.sv
module wp_seq_matcher
  import wp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CMP_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              bypass,
  input  logic              flush,
  output logic              is_cmd,
  output logic              arm_done,
  output logic              disarm_done
);
  localparam logic [CMP_W-1:0] A_ADR = CMP_W'(KEY_A_ADDR);
  localparam logic [CMP_W-1:0] B_ADR = CMP_W'(KEY_B_ADDR);

  seq_t st, nxt;
  logic at_a, at_b, key1, key2, restart;

  assign at_a = (wr_addr[CMP_W-1:0] == A_ADR);
  assign at_b = (wr_addr[CMP_W-1:0] == B_ADR);
  assign key1 = at_a && (wr_data == KEY_A_DATA);
  assign key2 = at_b && (wr_data == KEY_B_DATA);

  always_comb begin
    nxt         = st;
    is_cmd      = 1'b0;
    arm_done    = 1'b0;
    disarm_done = 1'b0;
    restart     = 1'b0;
    if (wr_valid && !bypass) begin
      case (st)
        SQ_IDLE: restart = 1'b1;
        SQ_KEY1: if (key2) begin nxt = SQ_KEY2; is_cmd = 1'b1; end
                 else restart = 1'b1;
        SQ_KEY2: begin
          if (at_a && wr_data == OP_ARM) begin
            nxt = SQ_IDLE; is_cmd = 1'b1; arm_done = 1'b1;
          end else if (at_a && wr_data == OP_ESCAPE) begin
            nxt = SQ_ESC3; is_cmd = 1'b1;
          end else restart = 1'b1;
        end
        SQ_ESC3: if (key1) begin nxt = SQ_ESC4; is_cmd = 1'b1; end
                 else restart = 1'b1;
        SQ_ESC4: if (key2) begin nxt = SQ_ESC5; is_cmd = 1'b1; end
                 else restart = 1'b1;
        SQ_ESC5: begin
          if (at_a && wr_data == OP_DISARM) begin
            nxt = SQ_IDLE; is_cmd = 1'b1; disarm_done = 1'b1;
          end else restart = 1'b1;
        end
        default: restart = 1'b1;
      endcase
      if (restart) begin
        is_cmd = key1;
        nxt    = key1 ? SQ_KEY1 : SQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush || bypass) st <= SQ_IDLE;
    else if (wr_valid)          st <= nxt;
  end

  // R10: an open window keeps the matcher idle
  a_r10_idle_in_window: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (st == SQ_IDLE));
  // R7: disarm can only finish from the last escape state
  a_r7_disarm_from_esc5: assert property (@(posedge clk) disable iff (rst)
    disarm_done |-> (st == SQ_ESC5));
endmodule

// File: rtl/wp_page_window.sv
module wp_page_window #(
  parameter int PAGE_BYTES = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic open_req,
  input  logic data_wr,
  input  logic close_req,
  output logic win_open
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAGE_BYTES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || close_req) begin
      win_open <= 1'b0;
      cnt      <= '0;
    end else if (open_req) begin
      win_open <= 1'b1;
      cnt      <= '0;
    end else if (win_open && data_wr) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) win_open <= 1'b0;
    end
  end

  // R6: a window only opens right after a completed command
  a_r6_open_after_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open) |-> $past(open_req));
  // R6: page_end always closes the window
  a_r6_close_on_end: assert property (@(posedge clk) disable iff (rst)
    close_req |=> !win_open);
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state #(
  parameter bit RETAIN_PROT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_done,
  input  logic disarm_done,
  input  logic page_end,
  output logic prot_q
);
  logic pend_arm, pend_disarm;

  always_ff @(posedge clk) begin
    if (rst || page_end) begin
      pend_arm    <= 1'b0;
      pend_disarm <= 1'b0;
    end else if (arm_done) begin
      pend_arm    <= 1'b1;
      pend_disarm <= 1'b0;
    end else if (disarm_done) begin
      pend_arm    <= 1'b0;
      pend_disarm <= 1'b1;
    end
  end

  generate
    if (RETAIN_PROT) begin : g_retained
      logic flag = 1'b0;
      always_ff @(posedge clk) begin
        if (page_end && pend_arm)         flag <= 1'b1;
        else if (page_end && pend_disarm) flag <= 1'b0;
      end
      assign prot_q = flag;
    end else begin : g_volatile
      logic flag;
      always_ff @(posedge clk) begin
        if (rst)                          flag <= 1'b0;
        else if (page_end && pend_arm)    flag <= 1'b1;
        else if (page_end && pend_disarm) flag <= 1'b0;
      end
      assign prot_q = flag;
    end
  endgenerate

  // R4: the flag moves only on the cycle after page_end
  a_r4_moves_on_end: assert property (@(posedge clk) disable iff (rst)
    (prot_q != $past(prot_q)) |-> $past(page_end));
  // R4: both pending requests are never held together
  a_r4_one_pending: assert property (@(posedge clk) disable iff (rst)
    !(pend_arm && pend_disarm));
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W      = 17,
  parameter int CMP_W       = 15,
  parameter int PAGE_BYTES  = 128,
  parameter bit RETAIN_PROT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              page_end,
  output logic              wr_allow,
  output logic              wr_cmd,
  output logic              prot_on
);
  logic is_cmd, arm_done, disarm_done, win_open, prot_q, allow_d;

  wp_seq_matcher #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .bypass(win_open), .flush(page_end),
    .is_cmd(is_cmd), .arm_done(arm_done), .disarm_done(disarm_done));

  wp_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
    .clk(clk), .rst(rst), .open_req(arm_done | disarm_done),
    .data_wr(wr_valid & ~is_cmd), .close_req(page_end),
    .win_open(win_open));

  wp_prot_state #(.RETAIN_PROT(RETAIN_PROT)) u_prot (
    .clk(clk), .rst(rst), .arm_done(arm_done), .disarm_done(disarm_done),
    .page_end(page_end), .prot_q(prot_q));

  assign allow_d = wr_valid && !is_cmd && (win_open || !prot_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_allow <= 1'b0;
      wr_cmd   <= 1'b0;
    end else begin
      wr_allow <= allow_d;
      wr_cmd   <= wr_valid && is_cmd;
    end
  end

  assign prot_on = prot_q;

  // R2: a verdict always answers a write of the previous cycle
  a_r2_verdict_needs_write: assert property (@(posedge clk) disable iff (rst)
    (wr_allow || wr_cmd) |-> $past(wr_valid));
  // R3: a byte is never both a command and loaded data
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_allow && wr_cmd));
  // R10: no command byte while a data window is open
  a_r10_no_cmd_in_window: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && win_open) |=> !wr_cmd);
endmodule

// File: tb/wp_guard_tb.sv
module wp_guard_tb;
  localparam int PB = 4;

  typedef struct packed {
    logic        pe;
    logic [16:0] a;
    logic [7:0]  d;
    logic        ea;
    logic        ec;
    logic        ep;
    logic [3:0]  rq;
  } vec_t;

  localparam int N = 31;
  localparam vec_t VEC [0:N-1] = '{
    '{1'b0, 17'h00010, 8'h11, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 plain write
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 key byte 1
    '{1'b0, 17'h00123, 8'h44, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 break -> data
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 break that restarts
    '{1'b0, 17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 key byte 2
    '{1'b0, 17'h1D555, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 upper bits ignored
    '{1'b0, 17'h00200, 8'h77, 1'b1, 1'b0, 1'b0, 4'd6},  // R6 data in window
    '{1'b0, 17'h05555, 8'hAA, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 key value as data
    '{1'b1, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 armed at page end
    '{1'b0, 17'h00300, 8'h12, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 dropped
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 unlock prefix
    '{1'b0, 17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd6},
    '{1'b0, 17'h05555, 8'hA0, 1'b0, 1'b1, 1'b1, 4'd6},
    '{1'b0, 17'h00400, 8'h09, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 unlocked data
    '{1'b1, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd6},
    '{1'b0, 17'h00401, 8'h09, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 window closed
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 disarm sequence
    '{1'b0, 17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd7},
    '{1'b0, 17'h05555, 8'h80, 1'b0, 1'b1, 1'b1, 4'd7},
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd7},
    '{1'b0, 17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b1, 4'd7},
    '{1'b0, 17'h05555, 8'h20, 1'b0, 1'b1, 1'b1, 4'd7},
    '{1'b1, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 disarmed at end
    '{1'b0, 17'h00500, 8'h03, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 arm, no data
    '{1'b0, 17'h02AAA, 8'h55, 1'b0, 1'b1, 1'b0, 4'd4},
    '{1'b0, 17'h05555, 8'hA0, 1'b0, 1'b1, 1'b0, 4'd4},
    '{1'b1, 17'h00000, 8'h00, 1'b0, 1'b0, 1'b1, 4'd4},  // R4
    '{1'b0, 17'h05555, 8'hAA, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 partial prefix
    '{1'b0, 17'h00600, 8'h5A, 1'b0, 1'b0, 1'b1, 4'd8}   // R8 break while protected
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic page_end = 1'b0;
  logic wr_allow, wr_cmd, prot_on;
  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  wp_guard #(.PAGE_BYTES(PB)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .page_end(page_end), .wr_allow(wr_allow),
    .wr_cmd(wr_cmd), .prot_on(prot_on));

  task automatic check(input string rq, input string what,
                       input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_end();
    @(negedge clk);
    page_end = 1'b1;
    @(negedge clk);
    page_end = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "allow after reset", wr_allow, 1'b0);
    check("R1", "cmd after reset", wr_cmd, 1'b0);
    check("R1", "prot after reset", prot_on, 1'b0);

    for (int i = 0; i < N; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
      if (VEC[i].pe) do_end();
      else do_write(VEC[i].a, VEC[i].d);
      check(tag, "allow", wr_allow, VEC[i].ea);
      check(tag, "cmd", wr_cmd, VEC[i].ec);
      check(tag, "prot", prot_on, VEC[i].ep);
    end

    // R9: reset keeps the retained protection flag
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "prot held in reset", prot_on, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "prot after reset", prot_on, 1'b1);
    check("R9", "allow after reset", wr_allow, 1'b0);

    // R6: window holds PB bytes, the next one is dropped
    do_write(17'h05555, 8'hAA);
    do_write(17'h02AAA, 8'h55);
    do_write(17'h05555, 8'hA0);
    check("R6", "prefix last cmd", wr_cmd, 1'b1);
    for (int k = 0; k < PB; k++) begin
      do_write(17'h00700 + 17'(k), 8'(k));
      check("R6", "byte in page", wr_allow, 1'b1);
    end
    do_write(17'h00710, 8'hEE);
    check("R6", "byte past page", wr_allow, 1'b0);
    check("R6", "byte past page cmd", wr_cmd, 1'b0);
    do_end();
    check("R6", "prot stays", prot_on, 1'b1);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule